// File: doc/BRIEF.md
# Double-Banked Macroblock Transfer Buffer

This block sits between two processing stages that run on independent schedules and exchange exactly one macroblock per interaction. It holds two macroblock-sized banks: while the producer fills one bank, the consumer can drain the other. Each side starts a transfer by raising its request. The buffer answers with a status line, and a macroblock transfer opens on the first clock edge where both request and status are high. Samples then move one per accepted cycle until the macroblock is complete.

A macroblock carries 256 luma samples plus its chroma samples. The chroma share doubles when the producer selects the 4:2:2 format instead of 4:2:0, so a macroblock holds 384 or 512 samples. The format is captured once per write, at its opening edge, and is kept with the bank. The reader is told the stored format, and its transfer length follows it. Banks are consumed in the order in which they were filled.

Top module: `mb_pingpong_buf`

## Requirements
- R1: After reset, `wr_stat` is 1, `rd_stat` is 0 and `rd_valid` is 0.
- R2: `wr_stat` is 1 exactly when no write transfer is open and the bank next in fill order is empty. With both banks holding unread macroblocks, it is 0.
- R3: `rd_stat` is 1 only when no read transfer is open and the bank next in drain order is full. A request raised while status is 0 is held, and its transfer opens on the first edge where status is 1.
- R4: A write opened with `wr_fmt`=0 (4:2:0) takes 384 samples, and one opened with `wr_fmt`=1 (4:2:2) takes 512. The bank becomes full, and `rd_stat` can rise, only at the edge that accepts the last sample.
- R5: `wr_fmt` is sampled only at the edge that opens a write. Changing it during the transfer has no effect. `rd_fmt` shows the stored format of the bank next to be drained (or being drained), and the read length follows that stored format.
- R6: Samples are read back in the order in which they were written, and macroblocks in the order in which they were filled.
- R7: A sample is accepted for reading at an edge with `rd_en` high while a read is open. `rd_data` is valid, with `rd_valid` high, in the following cycle. `rd_last` is high together with `rd_valid` on the final sample of the macroblock.
- R8: `wr_valid` while no write is open, and `rd_en` while no read is open, have no effect: no sample is stored and `rd_valid` stays 0.
- R9: A bank becomes empty, and `wr_stat` can rise again, only at the edge that accepts its last read sample.
- R10: Filling one bank and draining the other can proceed in the same cycles without affecting each other's data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_req | input | 1 | Producer request to start a macroblock write |
| wr_fmt | input | 1 | Chroma format for the write: 0 = 4:2:0, 1 = 4:2:2 |
| wr_stat | output | 1 | Write status: a bank is free and no write is open |
| wr_valid | input | 1 | Write sample present |
| wr_data | input | DATA_W | Write sample |
| rd_req | input | 1 | Consumer request to start a macroblock read |
| rd_stat | output | 1 | Read status: a bank is full and no read is open |
| rd_fmt | output | 1 | Stored chroma format of the bank at the read side |
| rd_en | input | 1 | Read sample request |
| rd_valid | output | 1 | Read sample valid |
| rd_data | output | DATA_W | Read sample |
| rd_last | output | 1 | Final sample of the macroblock |

## Verification
The checker keeps its own count of full banks from write and read completions. Its properties therefore assume that each side drives exactly one macroblock's worth of accepted samples per opened transfer, and that reads are requested only through the status handshake. The stimulus follows both rules. Its writer and reader tasks raise requests and wait on status, and they derive each transfer length from the format sent or from the stored format reported. Stray `wr_valid` and `rd_en` pulses are driven only while no transfer is open.

// File: rtl/mbb_pkg.sv
package mbb_pkg;
  typedef enum logic [1:0] {
    BK_EMPTY = 2'd0,
    BK_FILL  = 2'd1,
    BK_FULL  = 2'd2,
    BK_DRAIN = 2'd3
  } bank_st_e;
endpackage

// File: rtl/mbb_seq.sv
// Transfer sequencer: opens on start, counts accepted steps, closes on the final one.
module mbb_seq #(
  parameter int IDX_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             step_i,
  input  logic [IDX_W-1:0] last_idx_i,
  output logic             open_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             done_o
);
  logic             open_q, open_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [IDX_W-1:0] last_q, last_d;
  logic             acc;

  assign acc    = open_q && step_i;
  assign done_o = acc && (idx_q == last_q);
  assign open_o = open_q;
  assign idx_o  = idx_q;

  always_comb begin
    open_d = open_q;
    idx_d  = idx_q;
    last_d = last_q;
    if (start_i) begin
      open_d = 1'b1;
      idx_d  = '0;
      last_d = last_idx_i;
    end else if (acc) begin
      idx_d = idx_q + IDX_W'(1);
      if (done_o) open_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      idx_q  <= '0;
      last_q <= '0;
    end else if (start_i || acc) begin
      open_q <= open_d;
      idx_q  <= idx_d;
      last_q <= last_d;
    end
  end
endmodule

// File: rtl/mbb_bank.sv
// State of one macroblock bank plus the format it was filled with.
module mbb_bank (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fill_start_i,
  input  logic              fill_done_i,
  input  logic              drain_start_i,
  input  logic              drain_done_i,
  input  logic              fmt_i,
  output mbb_pkg::bank_st_e st_o,
  output logic              fmt_o
);
  import mbb_pkg::*;

  bank_st_e st_q, st_d;
  logic     fmt_q;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      BK_EMPTY: if (fill_start_i)  st_d = BK_FILL;
      BK_FILL:  if (fill_done_i)   st_d = BK_FULL;
      BK_FULL:  if (drain_start_i) st_d = BK_DRAIN;
      BK_DRAIN: if (drain_done_i)  st_d = BK_EMPTY;
      default:                     st_d = BK_EMPTY;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= BK_EMPTY;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            fmt_q <= 1'b0;
    else if (fill_start_i) fmt_q <= fmt_i;
  end

  assign st_o  = st_q;
  assign fmt_o = fmt_q;
endmodule

// File: rtl/mbb_store.sv
// Sample storage for all banks: one write port, one registered read port.
module mbb_store #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              re_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int WORDS = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [WORDS];
  logic [DATA_W-1:0] rdata_q;

  always_ff @(posedge clk) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  always_ff @(posedge clk) begin
    if (re_i) rdata_q <= mem[raddr_i];
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/mb_pingpong_buf.sv
module mb_pingpong_buf #(
  parameter int DATA_W   = 8,
  parameter int LUMA_N   = 256,
  parameter int CHROMA_N = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_req,
  input  logic              wr_fmt,
  output logic              wr_stat,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_req,
  output logic              rd_stat,
  output logic              rd_fmt,
  input  logic              rd_en,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_last
);
  import mbb_pkg::*;

  localparam int NBANK   = 2;
  localparam int PTR_W   = $clog2(NBANK);
  localparam int LEN_420 = LUMA_N + CHROMA_N;
  localparam int LEN_422 = LUMA_N + 2 * CHROMA_N;
  localparam int IDX_W   = $clog2(LEN_422);
  localparam int ADDR_W  = PTR_W + IDX_W;
  localparam logic [IDX_W-1:0] LAST_420 = IDX_W'(LEN_420 - 1);
  localparam logic [IDX_W-1:0] LAST_422 = IDX_W'(LEN_422 - 1);

  logic [PTR_W-1:0] wr_ptr_q, wr_ptr_d, rd_ptr_q, rd_ptr_d;
  logic             wr_open, wr_done, wr_go, wr_step;
  logic             rd_open, rd_done, rd_go, rd_step;
  logic [IDX_W-1:0] wr_idx, rd_idx, wr_last_idx, rd_last_idx;
  logic [NBANK-1:0] fill_start, fill_done, drain_start, drain_done, bank_fmt;
  bank_st_e         bank_st [NBANK];
  logic             rd_valid_q, rd_last_q;

  // status and transfer opening
  assign wr_stat     = !wr_open && (bank_st[wr_ptr_q] == BK_EMPTY);
  assign rd_stat     = !rd_open && (bank_st[rd_ptr_q] == BK_FULL);
  assign wr_go       = wr_req && wr_stat;
  assign rd_go       = rd_req && rd_stat;
  assign wr_step     = wr_open && wr_valid;
  assign rd_step     = rd_open && rd_en;
  assign rd_fmt      = bank_fmt[rd_ptr_q];
  assign wr_last_idx = wr_fmt ? LAST_422 : LAST_420;
  assign rd_last_idx = rd_fmt ? LAST_422 : LAST_420;

  mbb_seq #(.IDX_W(IDX_W)) u_wseq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (wr_go),
    .step_i     (wr_valid),
    .last_idx_i (wr_last_idx),
    .open_o     (wr_open),
    .idx_o      (wr_idx),
    .done_o     (wr_done)
  );

  mbb_seq #(.IDX_W(IDX_W)) u_rseq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (rd_go),
    .step_i     (rd_en),
    .last_idx_i (rd_last_idx),
    .open_o     (rd_open),
    .idx_o      (rd_idx),
    .done_o     (rd_done)
  );

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    assign fill_start[b]  = wr_go   && (wr_ptr_q == PTR_W'(b));
    assign fill_done[b]   = wr_done && (wr_ptr_q == PTR_W'(b));
    assign drain_start[b] = rd_go   && (rd_ptr_q == PTR_W'(b));
    assign drain_done[b]  = rd_done && (rd_ptr_q == PTR_W'(b));

    mbb_bank u_bank (
      .clk           (clk),
      .rst_n         (rst_n),
      .fill_start_i  (fill_start[b]),
      .fill_done_i   (fill_done[b]),
      .drain_start_i (drain_start[b]),
      .drain_done_i  (drain_done[b]),
      .fmt_i         (wr_fmt),
      .st_o          (bank_st[b]),
      .fmt_o         (bank_fmt[b])
    );
  end

  // bank pointers advance when a macroblock completes on that side
  always_comb begin
    wr_ptr_d = wr_done ? wr_ptr_q + PTR_W'(1) : wr_ptr_q;
    rd_ptr_d = rd_done ? rd_ptr_q + PTR_W'(1) : rd_ptr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
    end
  end

  mbb_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_store (
    .clk     (clk),
    .we_i    (wr_step),
    .waddr_i ({wr_ptr_q, wr_idx}),
    .wdata_i (wr_data),
    .re_i    (rd_step),
    .raddr_i ({rd_ptr_q, rd_idx}),
    .rdata_o (rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid_q <= 1'b0;
      rd_last_q  <= 1'b0;
    end else begin
      rd_valid_q <= rd_step;
      rd_last_q  <= rd_done;
    end
  end

  assign rd_valid = rd_valid_q;
  assign rd_last  = rd_last_q;
endmodule

// File: rtl/mbb_chk.sv
module mbb_chk (
  input logic clk,
  input logic rst_n,
  input logic wr_stat,
  input logic rd_stat,
  input logic rd_en,
  input logic rd_valid,
  input logic rd_last,
  input logic rd_fmt,
  input logic wr_done,
  input logic rd_done,
  input logic rd_open
);
  // number of banks holding a complete, not yet fully read macroblock
  logic [1:0] occ_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) occ_q <= 2'd0;
    else if (wr_done && !rd_done) occ_q <= occ_q + 2'd1;
    else if (rd_done && !wr_done) occ_q <= occ_q - 2'd1;
  end

  AST_FULL_BLOCKS_WRITE: assert property (@(posedge clk) disable iff (!rst_n) (occ_q == 2'd2) |-> !wr_stat); // R2
  AST_EMPTY_BLOCKS_READ: assert property (@(posedge clk) disable iff (!rst_n) (occ_q == 2'd0) |-> !rd_stat); // R3
  AST_OCC_BOUND:         assert property (@(posedge clk) disable iff (!rst_n) occ_q != 2'd3); // R9
  AST_NO_DRAIN_EMPTY:    assert property (@(posedge clk) disable iff (!rst_n) rd_done |-> (occ_q != 2'd0)); // R9
  AST_VALID_AFTER_EN:    assert property (@(posedge clk) disable iff (!rst_n) rd_valid |-> $past(rd_en)); // R7
  AST_LAST_WITH_VALID:   assert property (@(posedge clk) disable iff (!rst_n) rd_last |-> rd_valid); // R7
  AST_FMT_HELD:          assert property (@(posedge clk) disable iff (!rst_n) (rd_open && $past(rd_open)) |-> $stable(rd_fmt)); // R5
endmodule

bind mb_pingpong_buf mbb_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_stat  (wr_stat),
  .rd_stat  (rd_stat),
  .rd_en    (rd_en),
  .rd_valid (rd_valid),
  .rd_last  (rd_last),
  .rd_fmt   (rd_fmt),
  .wr_done  (wr_done),
  .rd_done  (rd_done),
  .rd_open  (rd_open)
);

// File: tb/mb_pingpong_buf_bench.sv
module mb_pingpong_buf_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_req, wr_fmt, wr_valid;
  logic [7:0] wr_data;
  logic       rd_req, rd_en;
  logic       wr_stat, rd_stat, rd_fmt, rd_valid, rd_last;
  logic [7:0] rd_data;

  typedef struct packed {
    logic [7:0] d;
    logic       last;
  } exp_t;

  exp_t exp_q[$];
  logic fmt_q[$];
  int   n_tests = 0;
  int   n_fail  = 0;
  bit   done_flag = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  mb_pingpong_buf u_mb_pingpong_buf (
    .clk(clk), .rst_n(rst_n),
    .wr_req(wr_req), .wr_fmt(wr_fmt), .wr_stat(wr_stat),
    .wr_valid(wr_valid), .wr_data(wr_data),
    .rd_req(rd_req), .rd_stat(rd_stat), .rd_fmt(rd_fmt),
    .rd_en(rd_en), .rd_valid(rd_valid), .rd_data(rd_data), .rd_last(rd_last)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int mb_len(input logic f);
    return f ? 512 : 384;
  endfunction

  // driver: opens a write via handshake, streams samples, records expectations
  task automatic write_mb(input logic fmt, input int seed, input bit flip, input bit chk_full);
    int n;
    wr_fmt = fmt;
    wr_req = 1'b1;
    while (!wr_stat) @(negedge clk);
    @(negedge clk);
    wr_req = 1'b0;
    fmt_q.push_back(fmt);
    if (flip) wr_fmt = ~fmt;
    n = mb_len(fmt);
    for (int i = 0; i < n; i++) begin
      logic [7:0] d;
      d = 8'((seed * 31 + i * 7) ^ (i >> 3));
      wr_valid = 1'b1;
      wr_data  = d;
      exp_q.push_back('{d: d, last: (i == n - 1)});
      if (chk_full && i == n - 1) chk(rd_stat == 1'b0, "R4 not full before last sample", rd_stat, 0);
      @(negedge clk);
    end
    wr_valid = 1'b0;
    if (chk_full) chk(rd_stat == 1'b1, "R4 full after last sample", rd_stat, 1);
  endtask

  task automatic read_mb(input bit chk_free);
    logic efmt;
    int   n;
    rd_req = 1'b1;
    while (!rd_stat) @(negedge clk);
    efmt = fmt_q.pop_front();
    chk(rd_fmt == efmt, "R5 stored format", rd_fmt, efmt);
    @(negedge clk);
    rd_req = 1'b0;
    n = mb_len(efmt);
    for (int i = 0; i < n; i++) begin
      rd_en = 1'b1;
      if (chk_free && i == n - 1) chk(wr_stat == 1'b0, "R9 not empty before last read", wr_stat, 0);
      @(negedge clk);
    end
    rd_en = 1'b0;
    if (chk_free) chk(wr_stat == 1'b1, "R9 empty after last read", wr_stat, 1);
  endtask

  // monitor: compares every delivered sample against the scoreboard
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R8 unexpected read sample", rd_data, -1);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(rd_data == e.d, "R6 read data", rd_data, e.d);
        chk(rd_last == e.last, "R7 last flag", rd_last, e.last);
      end
    end
  end

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    rst_n = 1'b0; wr_req = 1'b0; wr_fmt = 1'b0; wr_valid = 1'b0; wr_data = '0;
    rd_req = 1'b0; rd_en = 1'b0;
    repeat (3) @(negedge clk);
    chk(wr_stat == 1'b1, "R1 wr_stat reset", wr_stat, 1);
    chk(rd_stat == 1'b0, "R1 rd_stat reset", rd_stat, 0);
    chk(rd_valid == 1'b0, "R1 rd_valid reset", rd_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R4, R2, R9: fill both banks, then drain
    write_mb(1'b0, 1, 1'b0, 1'b1);
    chk(wr_stat == 1'b1, "R2 one bank still free", wr_stat, 1);
    write_mb(1'b1, 2, 1'b0, 1'b0);
    chk(wr_stat == 1'b0, "R2 both banks full", wr_stat, 0);
    read_mb(1'b1);
    read_mb(1'b0);
    repeat (3) @(negedge clk);

    // R5: format changed mid-write has no effect
    write_mb(1'b1, 3, 1'b1, 1'b0);
    write_mb(1'b0, 4, 1'b1, 1'b0);
    read_mb(1'b0);
    read_mb(1'b0);
    repeat (3) @(negedge clk);

    // R3: read request held while nothing is full
    fork
      read_mb(1'b0);
      begin
        repeat (8) begin
          @(negedge clk);
          chk(rd_stat == 1'b0, "R3 no status while empty", rd_stat, 0);
        end
        write_mb(1'b0, 5, 1'b0, 1'b0);
      end
    join
    repeat (3) @(negedge clk);

    // R10: concurrent fill and drain, mixed formats
    fork
      begin
        write_mb(1'b0, 6, 1'b0, 1'b0);
        write_mb(1'b1, 7, 1'b0, 1'b0);
        write_mb(1'b1, 8, 1'b0, 1'b0);
        write_mb(1'b0, 9, 1'b0, 1'b0);
      end
      begin
        repeat (4) read_mb(1'b0);
      end
    join
    repeat (3) @(negedge clk);

    // R8: stray samples and read enables with nothing open
    for (int i = 0; i < 6; i++) begin
      wr_valid = 1'b1;
      wr_data  = 8'hA5 ^ 8'(i);
      rd_en    = 1'b1;
      @(negedge clk);
      chk(rd_valid == 1'b0, "R8 rd_en ignored when idle", rd_valid, 0);
      chk(rd_stat == 1'b0, "R8 stray write stores nothing", rd_stat, 0);
    end
    wr_valid = 1'b0;
    rd_en    = 1'b0;
    write_mb(1'b1, 10, 1'b0, 1'b1);
    read_mb(1'b0);
    repeat (3) @(negedge clk);

    chk(exp_q.size() == 0, "R6 all samples delivered", exp_q.size(), 0);
    finish_run();
  end
endmodule